// File: doc/BRIEF.md
# Horizontal Line Scaler for 4:2:2 Video

This block resizes each video line along the horizontal axis. Pixels arrive one per accepted word, each with an 8-bit luma value and one 8-bit chroma value. Chroma alternates between Cb and Cr along the line. A per-line window picks the span of input pixels to process. A 12-bit fractional phase accumulator then decides how many output pixels each input pixel yields. Output luma is a two-tap linear blend of the previous and current input luma. Output chroma is rebuilt so that the output stream again alternates Cb, Cr, Cb, Cr from the start of each line.

The increment register gives the share of an output pixel that each input pixel is worth, in units of 1/4096. In normal mode an increment of 4096 would be unity, so any nonzero 12-bit increment downscales. In the byte-serial mode used for 656-style input, the increment counts double, so 2048 is unity and larger values upscale. In that mode one input pixel may yield two output pixels. The second one leaves on the following cycle. A zero increment always gives exactly one output per processed input. Configuration inputs are held stable while a line is in flight.

Top module: `hscale_core`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `out_valid` is 0.
- R2: Input pixels are numbered from 0 at the pixel marked with `in_sol`. Only pixels whose index k satisfies `cfg_offset` <= k < `cfg_offset`+`cfg_count` advance the phase or produce output. All other pixels of the line produce nothing.
- R3: In normal mode (`cfg_mode656`=0) each processed pixel adds `cfg_xinc` to the phase. When the sum reaches 4096 or more, one output is produced and 4096 is subtracted. At most one output is produced per input.
- R4: With `cfg_xinc`=0, in either mode, every processed pixel produces exactly one output, and its luma equals that pixel's luma.
- R5: In 656 mode (`cfg_mode656`=1) each processed pixel adds 2*`cfg_xinc`. Sums of 4096 or more produce one output, and sums of 8192 or more produce two, with 4096 removed per output. The second output appears on the cycle after the first. In this mode inputs are at least two cycles apart.
- R6: Output luma is (cur*(16-w) + prev*w)/16, truncated. Here cur is the current input luma and prev is the luma of the previous input pixel of the line (the pixel itself at line start). For a single output, w is bits [11:8] of the remaining phase. For a pair of outputs, the first uses w=15 and the second uses bits [11:8] of the final remainder.
- R7: Input pixels with an even index carry Cb and odd ones carry Cr. Outputs alternate Cb then Cr from each line start, with `out_cr`=1 marking Cr. Each output carries the latest value of that kind received up to and including the current input. Before the first one arrives after reset, that value is 0x80.
- R8: A line start clears the pixel index, the phase and the chroma alternation. The result of a line does not depend on the line before it, apart from the held chroma values of R7.
- R9: An output is presented on the cycle after the clock edge that accepted its input pixel (or on the cycle after that, for the second output of a pair).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode656 | input | 1 | 1 selects doubled increment (656-style input) |
| cfg_xinc | input | 12 | Phase increment per input pixel, 0 = unity |
| cfg_offset | input | 11 | Pixels skipped at line start |
| cfg_count | input | 11 | Pixels processed after the offset |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | Marks the first pixel of a line (with in_valid) |
| in_y | input | 8 | Input luma |
| in_c | input | 8 | Input chroma (Cb at even index, Cr at odd) |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma |
| out_cr | output | 1 | 1 when out_c is Cr, 0 when Cb |

## Verification
On every cycle the assertions check the timing skeleton. Outputs only follow an accepted pixel or a pending second output, and pixels outside the window stay silent. A pending output always leaves on the next cycle, normal mode never holds one, and the unity increment passes luma through. The phase arithmetic, the interpolation weights, the chroma alternation and the line-to-line independence can only be shown by the bench's scenarios. The bench compares every output value and its arrival cycle against a model in its queue, across downscale, unity and upscale settings in both modes.

// File: rtl/hscale_pkg.sv
package hscale_pkg;
  parameter int DW = 8;   // sample width
  parameter int PW = 12;  // phase fraction bits
  parameter int WB = 4;   // interpolation weight bits

  // two-tap blend: weight w pulls towards prev
  function automatic logic [DW-1:0] hs_lerp(input logic [DW-1:0] cur,
                                            input logic [DW-1:0] prev,
                                            input logic [WB-1:0] w);
    logic [DW+WB:0] a, b, s;
    a = (DW+WB+1)'(cur) * ((DW+WB+1)'(1 << WB) - (DW+WB+1)'(w));
    b = (DW+WB+1)'(prev) * (DW+WB+1)'(w);
    s = a + b;
    return s[DW+WB-1:WB];
  endfunction

  // weight taken from the top bits of a fractional remainder
  function automatic logic [WB-1:0] hs_weight(input logic [PW-1:0] rem);
    return rem[PW-1 -: WB];
  endfunction
endpackage

// File: rtl/hscale_span_gate.sv
module hscale_span_gate #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          sol_v,
  input  logic [CW-1:0] cfg_offset,
  input  logic [CW-1:0] cfg_count,
  output logic          active,
  output logic          odd_idx
);
  localparam logic [CW-1:0] IDX_MAX = '1;

  logic [CW-1:0] idx_q, idx_cur;
  logic [CW:0]   span_end;

  assign idx_cur  = sol_v ? '0 : idx_q;
  assign span_end = {1'b0, cfg_offset} + {1'b0, cfg_count};
  assign active   = in_valid && (idx_cur >= cfg_offset) && ({1'b0, idx_cur} < span_end);
  assign odd_idx  = idx_cur[0];

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (in_valid) idx_q <= (idx_cur == IDX_MAX) ? idx_cur : idx_cur + 1'b1;
  end
endmodule

// File: rtl/hscale_phase_acc.sv
module hscale_phase_acc
  import hscale_pkg::*;
#(
  parameter int XW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          restart,
  input  logic          mode656,
  input  logic [XW-1:0] xinc,
  output logic [1:0]    n_out,
  output logic [WB-1:0] w_first,
  output logic [WB-1:0] w_second
);
  localparam int AW = PW + 2;
  localparam logic [AW-1:0] ONE = AW'(1) << PW;
  localparam logic [AW-1:0] TWO = AW'(2) << PW;

  logic [AW-1:0] acc_q, acc_in, step, sum, r1, r2;

  assign acc_in = restart ? '0 : acc_q;
  always_comb begin
    if (xinc == '0)   step = ONE;
    else if (mode656) step = AW'({xinc, 1'b0});
    else              step = AW'(xinc);
  end
  assign sum = acc_in + step;
  assign r1  = sum - ONE;
  assign r2  = sum - TWO;

  always_comb begin
    n_out = 2'd0;
    if (advance) begin
      if (sum >= TWO)      n_out = 2'd2;
      else if (sum >= ONE) n_out = 2'd1;
    end
  end
  assign w_first  = (n_out == 2'd2) ? '1 : hs_weight(r1[PW-1:0]);
  assign w_second = hs_weight(r2[PW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (advance)
      acc_q <= (n_out == 2'd2) ? r2 : (n_out == 2'd1) ? r1 : sum;
    else if (restart) acc_q <= '0;
  end
endmodule

// File: rtl/hscale_core.sv
module hscale_core
  import hscale_pkg::*;
#(
  parameter int CW = 11,
  parameter int XW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode656,
  input  logic [XW-1:0] cfg_xinc,
  input  logic [CW-1:0] cfg_offset,
  input  logic [CW-1:0] cfg_count,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_c,
  output logic          out_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_c,
  output logic          out_cr
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  logic          sol_v, active_w, odd_w;
  logic [1:0]    n_w;
  logic [WB-1:0] w1_w, w2_w;

  assign sol_v = in_valid & in_sol;

  hscale_span_gate #(.CW(CW)) gate_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sol_v(sol_v),
    .cfg_offset(cfg_offset), .cfg_count(cfg_count),
    .active(active_w), .odd_idx(odd_w));

  hscale_phase_acc #(.XW(XW)) acc_i (
    .clk(clk), .rst_n(rst_n), .advance(active_w), .restart(sol_v),
    .mode656(cfg_mode656), .xinc(cfg_xinc),
    .n_out(n_w), .w_first(w1_w), .w_second(w2_w));

  logic [DW-1:0] prev_q, cb_q, cr_q, prev_sel, cb_new, cr_new;
  logic [DW-1:0] y1, y2, c1, c2, pend_y, pend_c;
  logic          par_q, par_cur, pend_q, pend_cr;

  assign prev_sel = sol_v ? in_y : prev_q;
  assign cb_new   = (in_valid && !odd_w) ? in_c : cb_q;
  assign cr_new   = (in_valid &&  odd_w) ? in_c : cr_q;
  assign par_cur  = sol_v ? 1'b0 : par_q;
  assign y1 = hs_lerp(in_y, prev_sel, w1_w);
  assign y2 = hs_lerp(in_y, prev_sel, w2_w);
  assign c1 = par_cur ? cr_new : cb_new;
  assign c2 = par_cur ? cb_new : cr_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= '0;
      out_cr    <= 1'b0;
      prev_q    <= '0;
      cb_q      <= MID;
      cr_q      <= MID;
      par_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_y    <= '0;
      pend_c    <= '0;
      pend_cr   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        prev_q <= in_y;
        cb_q   <= cb_new;
        cr_q   <= cr_new;
      end
      if (pend_q) begin
        out_valid <= 1'b1;
        out_y     <= pend_y;
        out_c     <= pend_c;
        out_cr    <= pend_cr;
        par_q     <= ~pend_cr;
        pend_q    <= 1'b0;
      end else if (n_w != 2'd0) begin
        out_valid <= 1'b1;
        out_y     <= y1;
        out_c     <= c1;
        out_cr    <= par_cur;
        par_q     <= ~par_cur;
        if (n_w == 2'd2) begin
          pend_q  <= 1'b1;
          pend_y  <= y2;
          pend_c  <= c2;
          pend_cr <= ~par_cur;
        end
      end else if (sol_v) begin
        par_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hscale_core_chk.sv
module hscale_core_chk #(
  parameter int CW = 11,
  parameter int XW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_mode656,
  input logic [XW-1:0] cfg_xinc,
  input logic          in_valid,
  input logic [7:0]    in_y,
  input logic          active_w,
  input logic          pend_q,
  input logic          out_valid,
  input logic [7:0]    out_y
);
  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !active_w && !pend_q |=> !out_valid);

  assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode656 && !$past(cfg_mode656) |-> !pend_q);

  assert_unity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && active_w && !pend_q && cfg_xinc == '0 |=> out_valid && out_y == $past(in_y));

  assert_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> out_valid);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid) || $past(pend_q));
endmodule

bind hscale_core hscale_core_chk #(.CW(CW), .XW(XW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mode656(cfg_mode656), .cfg_xinc(cfg_xinc),
  .in_valid(in_valid), .in_y(in_y), .active_w(active_w), .pend_q(pend_q),
  .out_valid(out_valid), .out_y(out_y));

// File: tb/hscale_core_tb.sv
module hscale_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_mode656 = 1'b0;
  logic [11:0] cfg_xinc = '0;
  logic [10:0] cfg_offset = '0, cfg_count = '0;
  logic in_valid = 1'b0, in_sol = 1'b0;
  logic [7:0] in_y = '0, in_c = '0;
  logic out_valid, out_cr;
  logic [7:0] out_y, out_c;

  always #4 clk = ~clk;

  hscale_core dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int q_y[$], q_c[$], q_cr[$], q_cyc[$];
  int m_prev = 0, m_cb = 128, m_cr = 128, m_acc = 0, m_idx = 0, m_par = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int blend(int cur, int prev, int w);
    return (cur * (16 - w) + prev * w) / 16;
  endfunction

  task automatic push(int y, int cyc_at);
    q_y.push_back(y);
    q_c.push_back(m_par ? m_cr : m_cb);
    q_cr.push_back(m_par);
    q_cyc.push_back(cyc_at);
    m_par = 1 - m_par;
  endtask

  // model of one accepted pixel (R2,R3,R5,R6,R7,R8)
  task automatic model_pixel(bit sol, int y, int c);
    int prev, step, sum, w;
    if (sol) begin m_idx = 0; m_acc = 0; m_par = 0; prev = y; end
    else prev = m_prev;
    if (m_idx % 2 == 0) m_cb = c; else m_cr = c;
    if (m_idx >= cfg_offset && m_idx < cfg_offset + cfg_count) begin
      step = (cfg_xinc == 0) ? 4096 : (cfg_mode656 ? 2 * cfg_xinc : cfg_xinc);
      sum = m_acc + step;
      if (sum >= 8192) begin
        push(blend(y, prev, 15), cyc + 1);
        m_acc = sum - 8192;
        push(blend(y, prev, m_acc / 256), cyc + 2);
      end else if (sum >= 4096) begin
        m_acc = sum - 4096;
        push(blend(y, prev, m_acc / 256), cyc + 1);
      end else m_acc = sum;
    end
    m_prev = y;
    m_idx++;
  endtask

  task automatic drive_line(int len, int gap, int base, int slope);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sol = (i == 0);
      in_y = 8'((base + i * slope) & 255);
      in_c = 8'((i * 37 + 11) & 255);
      model_pixel(i == 0, int'(in_y), int'(in_c));
      for (int j = 1; j < gap; j++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sol = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sol = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compares outputs and their arrival cycle (R6, R7, R9)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_y.size() == 0) check(0, "R2", "unexpected output", int'(out_y), -1);
      else begin
        check(int'(out_y) == q_y[0], "R6", "luma", int'(out_y), q_y[0]);
        check(int'(out_c) == q_c[0], "R7", "chroma", int'(out_c), q_c[0]);
        check(int'(out_cr) == q_cr[0], "R7", "cr flag", int'(out_cr), q_cr[0]);
        check(cyc == q_cyc[0], "R9", "arrival cycle", cyc, q_cyc[0]);
        void'(q_y.pop_front()); void'(q_c.pop_front());
        void'(q_cr.pop_front()); void'(q_cyc.pop_front());
      end
    end
  end

  task automatic drained(string req);
    check(q_y.size() == 0, req, "missing outputs", q_y.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R4 unity, R2 window with ignored tail
    cfg_mode656 = 0; cfg_xinc = 0; cfg_offset = 2; cfg_count = 6;
    drive_line(12, 1, 20, 9);
    drained("R4");
    // R3 downscale 0.75
    cfg_xinc = 3072; cfg_offset = 1; cfg_count = 12;
    drive_line(16, 1, 200, -7);
    drained("R3");
    // R3 near-unity step, with gaps between pixels
    cfg_xinc = 4095; cfg_offset = 0; cfg_count = 10;
    drive_line(10, 3, 5, 23);
    drained("R3");
    // R8 back-to-back lines, second restarts phase and parity
    cfg_xinc = 1500; cfg_offset = 3; cfg_count = 9;
    drive_line(13, 1, 90, 11);
    drive_line(13, 1, 10, 17);
    drained("R8");
    // R2 empty window produces nothing
    cfg_count = 0;
    drive_line(8, 1, 60, 3);
    drained("R2");
    // R5 656 mode unity and upscale
    cfg_mode656 = 1; cfg_xinc = 2048; cfg_offset = 1; cfg_count = 8;
    drive_line(10, 2, 30, 13);
    drained("R5");
    cfg_xinc = 3000; cfg_offset = 0; cfg_count = 12;
    drive_line(12, 2, 240, -19);
    drained("R5");
    cfg_xinc = 4095;
    drive_line(9, 3, 0, 29);
    drained("R5");
    // R4 zero increment in 656 mode
    cfg_xinc = 0; cfg_offset = 4; cfg_count = 5;
    drive_line(11, 2, 77, 5);
    drained("R4");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule